// File: doc/BRIEF.md
# Descriptor Ring Transmit/Receive DMA Engine

This block walks two circular lists of descriptors, one for sending and one for receiving, held in a shared word-addressed memory. Each descriptor occupies three consecutive 32-bit words. Word 0 holds control and status, word 1 holds lengths, and word 2 holds the buffer address. Software prepares a descriptor and passes it to the engine by setting its ownership bit. The engine returns the descriptor by clearing that bit after writing back its results. No descriptor counter exists: the last descriptor of a list carries an end-of-list bit, and the engine then returns to the list base address.

The send side starts only on a start pulse and keeps running until it meets a descriptor it does not own. Frame data movement is modelled as a counted stream of buffer word addresses. The receive side runs while its enable flag is set. It stores incoming stream words at consecutive buffer addresses and reports the received length and any error. It drops its enable flag when it meets a descriptor it does not own, or at the first descriptor boundary after a stop pulse. Both sides share one memory port, and the send side has priority.

Top module: `ring_dma`

## Requirements
- R1: After reset, `tx_busy`, `rx_enabled` and `mem_req` are low. A `tx_kick` pulse raises `tx_busy` on the next clock edge, and the engine then reads word 0 of its current send descriptor. The first kick after reset starts at `tx_base`.
- R2: A descriptor is processed only while bit 31 (owned) of its word 0 is set. When the send side reads a word 0 with bit 31 clear, it stops, drops `tx_busy` and emits no stream words for that descriptor.
- R3: For an owned send descriptor, the engine emits as many stream words as word 1 bits 31:16 give. The addresses run buffer, buffer+4, buffer+8 and so on, and `tx_last` is set on the final word. A length of zero emits no word. A word not taken by `tx_ready` holds its address.
- R4: Write-back of a send descriptor rewrites word 0 with bit 31 cleared. All other bits of word 0 are kept, including bit 30 (end-of-list) and the frame-position field in bits 29:28.
- R5: After a descriptor whose word 0 bit 30 is set, the next descriptor fetched is at the list base. Otherwise it is 12 bytes further on. This holds for both lists.
- R6: An `rx_en_set` pulse raises `rx_enabled` on the next edge. The receive side clears `rx_enabled` when it reads a descriptor with bit 31 clear. A later pulse resumes at that same descriptor.
- R7: On the last beat of a received frame, the engine writes word 1 as {buffer size in bits 31:16, stored word count in bits 15:0}. It then writes word 0 with bit 31 cleared and bit 30 kept. Each accepted beat appears on the store port one cycle later, at buffer+4*n.
- R8: Word 0 bit 27 (frame error) is written as 1 when any beat of the frame had `rx_err` set. Otherwise it is written as 0, whatever its earlier value.
- R9: Beats beyond the buffer size (word 1 bits 31:16 as fetched) are accepted but not stored. The reported length is then the buffer size, and bit 27 is set.
- R10: When both sides request the memory in the same cycle, the send side is served first. A request that is not granted is held, unchanged, until it is granted.
- R11: `tx_done_irq` and `rx_done_irq` each pulse for exactly one cycle per descriptor returned. The pulse comes in the cycle after the granted word 0 write.
- R12: A `tx_kick` while `tx_busy` is high has no effect. A kick after the engine has gone idle resumes at the descriptor where it stopped, not at the base.
- R13: After an `rx_stop` pulse, the receive side finishes the current descriptor and then clears `rx_enabled` without fetching the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_base | input | 32 | Send list base address (word aligned) |
| rx_base | input | 32 | Receive list base address (word aligned) |
| tx_kick | input | 1 | Send start pulse |
| tx_busy | output | 1 | Send request flag, low once the send side is idle |
| rx_en_set | input | 1 | Receive enable pulse |
| rx_stop | input | 1 | Receive stop pulse |
| rx_enabled | output | 1 | Receive enable flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; read data valid and write done in this cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Send stream word valid |
| tx_addr | output | 32 | Buffer address of the send word |
| tx_last | output | 1 | Final word of the frame |
| tx_ready | input | 1 | Send stream sink ready |
| rx_valid | input | 1 | Receive beat valid |
| rx_data | input | 32 | Receive beat data |
| rx_err | input | 1 | Receive beat error |
| rx_last | input | 1 | Final beat of the frame |
| rx_ready | output | 1 | Receive beat accepted |
| rx_st_valid | output | 1 | Store strobe for a received word |
| rx_st_addr | output | 32 | Store address |
| rx_st_data | output | 32 | Store data |
| tx_done_irq | output | 1 | Send descriptor returned pulse |
| rx_done_irq | output | 1 | Receive descriptor returned pulse |

## Verification
`tx_busy` and `rx_enabled` follow their pulses one edge later. The arbitration check is sampled on the falling edge one cycle after a simultaneous kick, with grants withheld. Each descriptor needs three read grants before its data phase. Its returned word 0 becomes visible in the bench memory on the same edge that raises the one-cycle completion pulse. Store strobes follow each accepted beat by one cycle. The bench therefore waits, with bounded loops, for the completion pulse or for the busy or enable flag to drop. It then reads back the descriptor words and the recorded stream addresses, so no check depends on a guessed latency.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
    localparam int DW        = 32;
    localparam int AW        = 32;
    localparam int LEN_W     = 16;
    localparam int OWN_BIT   = 31;
    localparam int EOL_BIT   = 30;
    localparam int FERR_BIT  = 27;
    localparam int WORD_B    = 4;
    localparam int DESC_W    = 3;
    localparam logic [AW-1:0] DESC_BYTES = AW'(DESC_W * WORD_B);
    localparam logic [DW-1:0] OWN_MASK   = DW'(1) << OWN_BIT;
    localparam logic [DW-1:0] FERR_MASK  = DW'(1) << FERR_BIT;

    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } mem_cmd_t;

    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_RD1, S_RD2, S_MOVE, S_WB1, S_WB0
    } walk_st_t;

    function automatic logic [AW-1:0] next_desc(input logic [AW-1:0] cur,
                                                input logic [DW-1:0] w0,
                                                input logic [AW-1:0] base);
        return w0[EOL_BIT] ? base : cur + DESC_BYTES;
    endfunction

    function automatic logic [AW-1:0] word_off(input logic [AW-1:0] buf_a,
                                               input logic [LEN_W-1:0] n);
        return buf_a + {{(AW-LEN_W-2){1'b0}}, n, 2'b00};
    endfunction
endpackage

// File: rtl/ring_dma_arb.sv
module ring_dma_arb import ring_dma_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  mem_cmd_t tx_cmd,
    input  mem_cmd_t rx_cmd,
    input  logic     mem_gnt,
    output mem_cmd_t mem_cmd,
    output logic     tx_gnt,
    output logic     rx_gnt
);
    always_comb begin
        tx_gnt  = tx_cmd.req & mem_gnt;
        rx_gnt  = rx_cmd.req & ~tx_cmd.req & mem_gnt;
        mem_cmd = tx_cmd.req ? tx_cmd : rx_cmd;
    end

    logic rx_req, tx_req;
    logic [AW-1:0] rx_a, tx_a;
    assign rx_req = rx_cmd.req;
    assign tx_req = tx_cmd.req;
    assign rx_a   = rx_cmd.addr;
    assign tx_a   = tx_cmd.addr;

    // R10
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rx_req && !rx_gnt |=> rx_req && $stable(rx_a));
    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_req && !tx_gnt |=> tx_req && $stable(tx_a));
endmodule

// File: rtl/ring_dma_tx.sv
module ring_dma_tx import ring_dma_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic          kick,
    output logic          busy,
    output mem_cmd_t      cmd,
    input  logic          gnt,
    input  logic [DW-1:0] rdata,
    output logic          s_valid,
    output logic [AW-1:0] s_addr,
    output logic          s_last,
    input  logic          s_ready,
    output logic          done_irq
);
    walk_st_t         state;
    logic [AW-1:0]    cur, buf_a;
    logic [DW-1:0]    w0;
    logic [LEN_W-1:0] len, cnt;
    logic             loaded;

    always_comb begin
        cmd = '0;
        unique case (state)
            S_RD0: begin cmd.req = 1'b1; cmd.addr = cur; end
            S_RD1: begin cmd.req = 1'b1; cmd.addr = cur + AW'(WORD_B); end
            S_RD2: begin cmd.req = 1'b1; cmd.addr = cur + AW'(2 * WORD_B); end
            S_WB0: begin
                cmd.req = 1'b1; cmd.we = 1'b1; cmd.addr = cur;
                cmd.wdata = w0 & ~OWN_MASK;
            end
            default: ;
        endcase
    end

    assign s_valid = (state == S_MOVE);
    assign s_addr  = word_off(buf_a, cnt);
    assign s_last  = (cnt == len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE; cur <= '0; buf_a <= '0; w0 <= '0;
            len <= '0; cnt <= '0; loaded <= 1'b0; busy <= 1'b0; done_irq <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            unique case (state)
                S_IDLE: if (kick) begin
                    busy  <= 1'b1;
                    state <= S_RD0;
                    if (!loaded) begin cur <= base; loaded <= 1'b1; end
                end
                S_RD0: if (gnt) begin
                    w0 <= rdata;
                    if (rdata[OWN_BIT]) state <= S_RD1;
                    else begin busy <= 1'b0; state <= S_IDLE; end
                end
                S_RD1: if (gnt) begin
                    len   <= rdata[DW-1 -: LEN_W];
                    state <= S_RD2;
                end
                S_RD2: if (gnt) begin
                    buf_a <= rdata;
                    cnt   <= '0;
                    state <= (len == '0) ? S_WB0 : S_MOVE;
                end
                S_MOVE: if (s_ready) begin
                    cnt <= cnt + LEN_W'(1);
                    if (s_last) state <= S_WB0;
                end
                S_WB0: if (gnt) begin
                    done_irq <= 1'b1;
                    cur      <= next_desc(cur, w0, base);
                    state    <= S_RD0;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R3
    stream_hold_chk: assert property (@(posedge clk) disable iff (rst)
        s_valid && !s_ready |=> s_valid && $stable(s_addr));
    // R2
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(gnt && !rdata[OWN_BIT]));
endmodule

// File: rtl/ring_dma_rx.sv
module ring_dma_rx import ring_dma_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic          en_set,
    input  logic          stop,
    output logic          enabled,
    output mem_cmd_t      cmd,
    input  logic          gnt,
    input  logic [DW-1:0] rdata,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_err,
    input  logic          in_last,
    output logic          in_ready,
    output logic          st_valid,
    output logic [AW-1:0] st_addr,
    output logic [DW-1:0] st_data,
    output logic          done_irq
);
    walk_st_t         state;
    logic [AW-1:0]    cur, buf_a;
    logic [DW-1:0]    w0;
    logic [LEN_W-1:0] bufsz, cnt;
    logic             loaded, err, trunc, stop_pend;
    logic             room;

    assign room     = (cnt < bufsz);
    assign in_ready = (state == S_MOVE);

    always_comb begin
        cmd = '0;
        unique case (state)
            S_RD0: begin cmd.req = 1'b1; cmd.addr = cur; end
            S_RD1: begin cmd.req = 1'b1; cmd.addr = cur + AW'(WORD_B); end
            S_RD2: begin cmd.req = 1'b1; cmd.addr = cur + AW'(2 * WORD_B); end
            S_WB1: begin
                cmd.req = 1'b1; cmd.we = 1'b1; cmd.addr = cur + AW'(WORD_B);
                cmd.wdata = {bufsz, cnt};
            end
            S_WB0: begin
                cmd.req = 1'b1; cmd.we = 1'b1; cmd.addr = cur;
                cmd.wdata = (w0 & ~(OWN_MASK | FERR_MASK)) |
                            ((err | trunc) ? FERR_MASK : '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE; cur <= '0; buf_a <= '0; w0 <= '0; bufsz <= '0;
            cnt <= '0; loaded <= 1'b0; err <= 1'b0; trunc <= 1'b0;
            stop_pend <= 1'b0; enabled <= 1'b0; done_irq <= 1'b0;
            st_valid <= 1'b0; st_addr <= '0; st_data <= '0;
        end else begin
            done_irq <= 1'b0;
            st_valid <= 1'b0;
            if (stop && enabled) stop_pend <= 1'b1;
            unique case (state)
                S_IDLE: if (en_set) begin
                    enabled   <= 1'b1;
                    stop_pend <= 1'b0;
                    state     <= S_RD0;
                    if (!loaded) begin cur <= base; loaded <= 1'b1; end
                end
                S_RD0: if (gnt) begin
                    w0 <= rdata;
                    if (rdata[OWN_BIT]) state <= S_RD1;
                    else begin enabled <= 1'b0; state <= S_IDLE; end
                end
                S_RD1: if (gnt) begin
                    bufsz <= rdata[DW-1 -: LEN_W];
                    state <= S_RD2;
                end
                S_RD2: if (gnt) begin
                    buf_a <= rdata;
                    cnt   <= '0;
                    err   <= 1'b0;
                    trunc <= 1'b0;
                    state <= S_MOVE;
                end
                S_MOVE: if (in_valid) begin
                    if (room) begin
                        cnt      <= cnt + LEN_W'(1);
                        st_valid <= 1'b1;
                        st_addr  <= word_off(buf_a, cnt);
                        st_data  <= in_data;
                    end else begin
                        trunc <= 1'b1;
                    end
                    if (in_err)  err   <= 1'b1;
                    if (in_last) state <= S_WB1;
                end
                S_WB1: if (gnt) state <= S_WB0;
                S_WB0: if (gnt) begin
                    done_irq <= 1'b1;
                    cur      <= next_desc(cur, w0, base);
                    if (stop_pend || (stop && enabled)) begin
                        enabled   <= 1'b0;
                        stop_pend <= 1'b0;
                        state     <= S_IDLE;
                    end else begin
                        state <= S_RD0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R9
    store_bound_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !room |=> !st_valid);
    // R6
    enable_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(enabled) |-> $past(gnt));
endmodule

// File: rtl/ring_dma.sv
module ring_dma import ring_dma_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] tx_base,
    input  logic [AW-1:0] rx_base,
    input  logic          tx_kick,
    output logic          tx_busy,
    input  logic          rx_en_set,
    input  logic          rx_stop,
    output logic          rx_enabled,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          tx_valid,
    output logic [AW-1:0] tx_addr,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_err,
    input  logic          rx_last,
    output logic          rx_ready,
    output logic          rx_st_valid,
    output logic [AW-1:0] rx_st_addr,
    output logic [DW-1:0] rx_st_data,
    output logic          tx_done_irq,
    output logic          rx_done_irq
);
    mem_cmd_t tx_cmd, rx_cmd, mem_cmd;
    logic     tx_gnt, rx_gnt;

    ring_dma_tx u_tx (
        .clk(clk), .rst(rst), .base(tx_base), .kick(tx_kick), .busy(tx_busy),
        .cmd(tx_cmd), .gnt(tx_gnt), .rdata(mem_rdata),
        .s_valid(tx_valid), .s_addr(tx_addr), .s_last(tx_last), .s_ready(tx_ready),
        .done_irq(tx_done_irq)
    );

    ring_dma_rx u_rx (
        .clk(clk), .rst(rst), .base(rx_base), .en_set(rx_en_set), .stop(rx_stop),
        .enabled(rx_enabled), .cmd(rx_cmd), .gnt(rx_gnt), .rdata(mem_rdata),
        .in_valid(rx_valid), .in_data(rx_data), .in_err(rx_err), .in_last(rx_last),
        .in_ready(rx_ready), .st_valid(rx_st_valid), .st_addr(rx_st_addr),
        .st_data(rx_st_data), .done_irq(rx_done_irq)
    );

    ring_dma_arb u_arb (
        .clk(clk), .rst(rst), .tx_cmd(tx_cmd), .rx_cmd(rx_cmd), .mem_gnt(mem_gnt),
        .mem_cmd(mem_cmd), .tx_gnt(tx_gnt), .rx_gnt(rx_gnt)
    );

    assign mem_req   = mem_cmd.req;
    assign mem_we    = mem_cmd.we;
    assign mem_addr  = mem_cmd.addr;
    assign mem_wdata = mem_cmd.wdata;

    // R11
    irq_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({tx_done_irq, rx_done_irq}) <= 1);
    // R11
    irq_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done_irq || rx_done_irq) |-> $past(mem_req && mem_we && mem_gnt));
    // R5
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: tb/sim_ring_dma.sv
module sim_ring_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tx_base = 32'h0, rx_base = 32'h40;
    logic        tx_kick = 0, rx_en_set = 0, rx_stop = 0;
    logic        tx_busy, rx_enabled;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_ready;
    logic [31:0] tx_addr;
    logic        rx_valid = 0, rx_err = 0, rx_last = 0, rx_ready;
    logic [31:0] rx_data = 0;
    logic        rx_st_valid;
    logic [31:0] rx_st_addr, rx_st_data;
    logic        tx_done_irq, rx_done_irq;

    always #4 clk = ~clk;

    ring_dma u0 (.*);

    logic [31:0] mem [64] = '{default: 32'h0};
    logic        gnt_en = 1'b1;
    logic        pk_en = 1'b0;
    logic [31:0] pk_a = 0, pk_d = 0;
    assign mem_gnt   = mem_req & gnt_en;
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (pk_en) mem[pk_a[7:2]] <= pk_d;
        else if (mem_req && mem_we && mem_gnt) mem[mem_addr[7:2]] <= mem_wdata;
    end

    int total = 0, failed = 0;
    int cyc = 0, txn = 0, tx_irqs = 0, rx_irqs = 0, stn = 0;
    logic [31:0] txa [32];
    logic        txl [32];
    logic [31:0] last_st;
    logic        slow_sink = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        tx_ready = slow_sink ? (cyc % 3 != 0) : 1'b1;
        if (tx_valid && tx_ready) begin
            if (txn < 32) begin txa[txn] = tx_addr; txl[txn] = tx_last; end
            txn = txn + 1;
        end
        if (tx_done_irq) tx_irqs = tx_irqs + 1;
        if (rx_done_irq) rx_irqs = rx_irqs + 1;
        if (rx_st_valid) begin stn = stn + 1; last_st = rx_st_addr; end
        if (cyc == 150000) begin
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("%0d/%0d checks passed", total - failed, total + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        pk_en = 1'b1; pk_a = a; pk_d = d;
        @(negedge clk);
        pk_en = 1'b0;
    endtask

    task automatic send_frame(input int beats, input int eb, input int tag);
        for (int b = 0; b < beats; b++) begin
            rx_valid = 1'b1; rx_last = (b == beats - 1); rx_err = (b == eb);
            rx_data = 32'(tag * 16 + b);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    // beats[31:24], error beat[23:16] (FF = none), expected length[15:8], expected error[0]
    localparam logic [31:0] RXV [4] = '{32'h03FF_0300, 32'h0401_0401,
                                        32'h06FF_0401, 32'h0100_0101};

    initial begin
        int t0, i0, s0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy after reset", {31'd0, tx_busy}, 32'd0);
        chk("R6 enabled after reset", {31'd0, rx_enabled}, 32'd0);
        chk("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
        rst = 1'b0;
        poke(32'h00, 32'hB000_0000); poke(32'h04, 32'h0003_0000); poke(32'h08, 32'h0000_1000);
        poke(32'h0C, 32'h9000_0000); poke(32'h10, 32'h0000_0000); poke(32'h14, 32'h0000_2000);
        poke(32'h18, 32'h0000_0000);
        poke(32'h40, 32'h0000_0000); poke(32'h4C, 32'h4000_0000);

        // R10 simultaneous requests with grants withheld
        gnt_en = 1'b0; t0 = txn; i0 = tx_irqs;
        tx_kick = 1'b1; rx_en_set = 1'b1;
        @(negedge clk);
        tx_kick = 1'b0; rx_en_set = 1'b0;
        chk("R1 busy after kick", {31'd0, tx_busy}, 32'd1);
        chk("R6 enabled after set", {31'd0, rx_enabled}, 32'd1);
        chk("R10 send served first", mem_addr, 32'h0000_0000);
        @(negedge clk);
        chk("R10 request held", mem_addr, 32'h0000_0000);
        gnt_en = 1'b1;
        for (int k = 0; k < 300 && tx_busy; k++) @(negedge clk);
        chk("R2 busy dropped at unowned", {31'd0, tx_busy}, 32'd0);
        chk("R3 word count", 32'(txn - t0), 32'd3);
        chk("R3 word0 addr", txa[t0], 32'h1000);
        chk("R3 word2 addr", txa[t0 + 2], 32'h1008);
        chk("R3 last flags", {29'd0, txl[t0], txl[t0 + 1], txl[t0 + 2]}, 32'd1);
        chk("R11 send pulses", 32'(tx_irqs - i0), 32'd2);
        chk("R4 own cleared, position kept", mem[0], 32'h3000_0000);
        chk("R4 zero-length returned", mem[3], 32'h1000_0000);
        chk("R2 unowned untouched", mem[6], 32'h0);
        chk("R6 enabled cleared at unowned", {31'd0, rx_enabled}, 32'd0);

        // R5 wrap, R12 resume and ignored kick, R3 backpressure
        poke(32'h18, 32'hC000_0000); poke(32'h1C, 32'h0001_0000); poke(32'h20, 32'h0000_2000);
        poke(32'h00, 32'h8000_0000); poke(32'h04, 32'h0002_0000); poke(32'h08, 32'h0000_3000);
        poke(32'h0C, 32'h0000_0000);
        slow_sink = 1'b1; t0 = txn; i0 = tx_irqs;
        tx_kick = 1'b1; @(negedge clk); tx_kick = 1'b0;
        repeat (3) @(negedge clk);
        tx_kick = 1'b1; @(negedge clk); tx_kick = 1'b0;
        for (int k = 0; k < 300 && tx_busy; k++) @(negedge clk);
        slow_sink = 1'b0;
        chk("R12 word count with extra kick", 32'(txn - t0), 32'd3);
        chk("R12 resumed at stop point", txa[t0], 32'h2000);
        chk("R5 wrapped to base", txa[t0 + 1], 32'h3000);
        chk("R3 held under backpressure", txa[t0 + 2], 32'h3004);
        chk("R4 end-of-list kept", mem[6], 32'h4000_0000);
        chk("R11 send pulses run 2", 32'(tx_irqs - i0), 32'd2);

        // receive vector table
        for (int v = 0; v < 4; v++) begin
            logic [31:0] d, o, eolb, vec;
            int beats, eb, stored;
            vec = RXV[v];
            d = (v % 2 == 0) ? 32'h40 : 32'h4C;
            o = (v % 2 == 0) ? 32'h4C : 32'h40;
            eolb = (v % 2 == 0) ? 32'h0 : 32'h4000_0000;
            beats = int'(vec[31:24]);
            eb = (vec[23:16] == 8'hFF) ? -1 : int'(vec[23:16]);
            stored = (beats < 4) ? beats : 4;
            poke(d, 32'h8800_0000 | eolb);
            poke(d + 4, 32'h0004_0000);
            poke(d + 8, 32'h5000 + 32'(v * 256));
            poke(o, (v % 2 == 0) ? 32'h4000_0000 : 32'h0);
            i0 = rx_irqs; s0 = stn;
            rx_en_set = 1'b1; @(negedge clk); rx_en_set = 1'b0;
            repeat (5) @(negedge clk);
            send_frame(beats, eb, v);
            for (int k = 0; k < 100 && rx_irqs == i0; k++) @(negedge clk);
            chk("R7 length word", mem[(d + 4) >> 2], {16'd4, 8'd0, vec[15:8]});
            chk("R8 R9 word0 status", mem[d >> 2], eolb | (vec[0] ? 32'h0800_0000 : 32'h0));
            chk("R9 stored beats", 32'(stn - s0), 32'(stored));
            chk("R7 last store addr", last_st, 32'h5000 + 32'(v * 256) + 32'((stored - 1) * 4));
            chk("R11 receive pulse", 32'(rx_irqs - i0), 32'd1);
            for (int k = 0; k < 50 && rx_enabled; k++) @(negedge clk);
            chk("R6 stop at unowned", {31'd0, rx_enabled}, 32'd0);
        end

        // R13 stop at descriptor boundary
        poke(32'h40, 32'h8000_0000); poke(32'h44, 32'h0004_0000); poke(32'h48, 32'h0000_7000);
        poke(32'h4C, 32'hC000_0000);
        i0 = rx_irqs;
        rx_en_set = 1'b1; @(negedge clk); rx_en_set = 1'b0;
        repeat (5) @(negedge clk);
        rx_stop = 1'b1; @(negedge clk); rx_stop = 1'b0;
        chk("R13 still enabled mid-frame", {31'd0, rx_enabled}, 32'd1);
        send_frame(2, -1, 9);
        for (int k = 0; k < 100 && rx_irqs == i0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R13 enabled cleared", {31'd0, rx_enabled}, 32'd0);
        chk("R13 next descriptor not taken", mem[19], 32'hC000_0000);
        chk("R13 current returned", mem[16], 32'h0000_0000);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule